// File: doc/BRIEF.md
# Triggered timebase divider with one-shot

This block is a synchronous timer. A timebase feeds an 8-bit binary divider chain, and control inputs start, stop and restart that chain. The timebase comes from one of two places. It can be an internal prescaler that makes a square wave with a programmable period, counted in system clock cycles. It can also be an external signal, which is synchronised and whose falling edges are counted. The selected timebase level is driven out. The first and last divider stages are also driven out, so the last stage of one instance can serve as the timebase of the next.

The chain rests in an idle state with both divided outputs high. A rising edge on the trigger clears every stage, so both divided outputs fall, and it also restarts the internal prescaler from the start of a period. From then on each timebase falling edge advances the chain by one. A mode pin selects between two behaviours. In free-running mode the last stage keeps producing a square wave. In one-shot mode the last stage rising acts as a reset, so one trigger yields a single low pulse of 128 timebase periods. A reset request returns the block to idle, but only while the trigger is low: the trigger always wins.

There is no data stream. Every pin is a plain level control or status signal, with no valid/ready handshake and no back-pressure. The trigger, reset request and external timebase pass through a two-flop synchroniser, so each takes effect on the third rising clock edge after the pin changes.

Top module: `tbd_oneshot`

## Requirements
- R1: After rst_n is released the block is idle. div2_o and div256_o are both 1, and timebase edges do not change them.
- R2: A rising edge on trig_i clears all divider bits, so div2_o=0 and div256_o=0, on the third clock edge after the pin rises. This also applies while the chain is running.
- R3: Each timebase falling edge adds one to the divider value n (8 bits, wrapping). div2_o is bit 0 of n and div256_o is bit 7 of n.
- R4: With tb_ext_sel_i=0 the timebase period is P = max(period_i, 2) clocks. A trigger restarts the timebase: tb_o is 0 for floor(P/2) clocks and then 1, and the first falling edge is counted exactly P clocks after the chain clears.
- R5: With astable_i=0, a trigger makes div256_o low for exactly 128 timebase falling edges. On the next clock the block is idle, with both outputs 1.
- R6: With astable_i=1, div256_o is a continuous square wave. Each half lasts 128 timebase falling edges.
- R7: A reset request (clr_i=1) while trig_i is low returns the block to idle on the third clock edge after clr_i rises. Later timebase edges are ignored.
- R8: While the synchronised trigger is high, both clr_i and the one-shot self-reset are ignored and counting continues.
- R9: With tb_ext_sel_i=1, only falling edges of tb_ext_i are counted, each on the third clock edge after the pin falls. tb_o follows tb_ext_i two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger; rising edge starts or restarts the chain |
| clr_i | input | 1 | Reset request, level, active high |
| tb_ext_i | input | 1 | External timebase |
| tb_ext_sel_i | input | 1 | 1 selects the external timebase |
| astable_i | input | 1 | 1 selects free-running mode, 0 selects one-shot mode |
| period_i | input | 16 | Internal timebase period in clocks (values below 2 act as 2) |
| tb_o | output | 1 | Selected timebase level |
| div2_o | output | 1 | First divider stage |
| div256_o | output | 1 | Last divider stage |

## Verification
Free-running runs use random periods and random tick counts up to 300. These runs check the binary count past the wrap point and set the exact tick spacing apart from off-by-one timing. Directed one-shot runs probe the 127th, 128th and 129th tick, which separates a correct pulse length from a one-tick error and from a missing self-reset. Reset requests are tried with the trigger low and with it held high, which shows whether the priority rule holds. External-edge runs show that only falling edges are counted and measure the synchroniser latency.

// File: rtl/tbd_pkg.sv
`timescale 1ns/1ps
package tbd_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} tbd_state_e;
  localparam int SB_TRIG = 0;
  localparam int SB_CLR  = 1;
  localparam int SB_EXT  = 2;
  localparam int SB_NUM  = 3;
endpackage

// File: rtl/tbd_sync.sv
`timescale 1ns/1ps
module tbd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tbd_tick.sv
`timescale 1ns/1ps
module tbd_tick #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tb_o,
  output logic             fall_o
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] per_eff;
  logic [PER_W-1:0] lo_len;
  logic             wrap;

  assign per_eff = (period_i < PER_W'(2)) ? PER_W'(2) : period_i;
  assign lo_len  = per_eff >> 1;
  assign wrap    = (cnt >= per_eff - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt <= '0;
    else if (restart_i) cnt <= '0;
    else if (wrap)      cnt <= '0;
    else                cnt <= cnt + PER_W'(1);

  assign tb_o   = (cnt >= lo_len);
  assign fall_o = wrap & ~restart_i;

  p_fall_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !tb_o);
  p_restart_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !tb_o);
endmodule

// File: rtl/tbd_chain.sv
`timescale 1ns/1ps
module tbd_chain
  import tbd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rise_i,
  input  logic             trig_lvl_i,
  input  logic             clr_lvl_i,
  input  logic             tick_i,
  input  logic             astable_i,
  output logic [DIV_W-1:0] q_o
);
  localparam int MSB = DIV_W - 1;

  tbd_state_e       st;
  logic [DIV_W-1:0] q;
  logic             rst_req;
  logic             rst_eff;

  assign rst_req = clr_lvl_i | (~astable_i & q[MSB]);
  assign rst_eff = rst_req & ~trig_lvl_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE;
      q  <= '1;
    end else if (trig_rise_i) begin
      st <= ST_RUN;
      q  <= '0;
    end else if (rst_eff) begin
      st <= ST_IDLE;
      q  <= '1;
    end else if (st == ST_RUN && tick_i) begin
      q  <= q + DIV_W'(1);
    end

  assign q_o = q;

  p_trig_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise_i |=> (q_o == '0 && st == ST_RUN));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && tick_i && !trig_rise_i && !rst_eff) |=> q_o == $past(q_o) + DIV_W'(1));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !trig_rise_i) |=> (st == ST_IDLE && &q_o));
  p_trig_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && trig_lvl_i) |=> st == ST_RUN);
  p_mono_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !astable_i && q_o[MSB] && !trig_lvl_i && !trig_rise_i) |=> st == ST_IDLE);
endmodule

// File: rtl/tbd_oneshot.sv
`timescale 1ns/1ps
module tbd_oneshot
  import tbd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PER_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             clr_i,
  input  logic             tb_ext_i,
  input  logic             tb_ext_sel_i,
  input  logic             astable_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tb_o,
  output logic             div2_o,
  output logic             div256_o
);
  logic [SB_NUM-1:0] raw, syn;
  logic              trig_d, ext_d;
  logic              trig_rise, ext_fall;
  logic              int_tb, int_fall, tick;
  logic [DIV_W-1:0]  q;

  assign raw[SB_TRIG] = trig_i;
  assign raw[SB_CLR]  = clr_i;
  assign raw[SB_EXT]  = tb_ext_i;

  tbd_sync #(.WIDTH(SB_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trig_d <= 1'b0;
      ext_d  <= 1'b0;
    end else begin
      trig_d <= syn[SB_TRIG];
      ext_d  <= syn[SB_EXT];
    end

  assign trig_rise = syn[SB_TRIG] & ~trig_d;
  assign ext_fall  = ext_d & ~syn[SB_EXT];

  tbd_tick #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart_i(trig_rise), .period_i(period_i),
    .tb_o(int_tb), .fall_o(int_fall));

  assign tick = tb_ext_sel_i ? ext_fall : int_fall;
  assign tb_o = tb_ext_sel_i ? syn[SB_EXT] : int_tb;

  tbd_chain #(.DIV_W(DIV_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .trig_rise_i(trig_rise), .trig_lvl_i(syn[SB_TRIG]),
    .clr_lvl_i(syn[SB_CLR]), .tick_i(tick), .astable_i(astable_i), .q_o(q));

  assign div2_o   = q[0];
  assign div256_o = q[DIV_W-1];

  p_ext_only_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_ext_sel_i && !trig_rise && !ext_fall) |=> $stable(q) || &q);
endmodule

// File: tb/sim_tbd_oneshot.sv
`timescale 1ns/1ps
module sim_tbd_oneshot;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0, clr_i = 1'b0, tb_ext_i = 1'b1, tb_ext_sel_i = 1'b0, astable_i = 1'b1;
  logic [15:0] period_i = 16'd4;
  logic tb_o, div2_o, div256_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbd_oneshot u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .clr_i(clr_i), .tb_ext_i(tb_ext_i),
    .tb_ext_sel_i(tb_ext_sel_i), .astable_i(astable_i), .period_i(period_i),
    .tb_o(tb_o), .div2_o(div2_o), .div256_o(div256_o));

  function automatic logic [1:0] exp_outs(int n);
    int m = n % 256;
    return {logic'(m >= 128), logic'(m % 2)};
  endfunction

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic outs(string req, logic [1:0] exp);
    chk(req, {div256_o, div2_o}, exp);
  endtask

  task automatic trig_pulse();
    trig_i = 1'b1;
    edges(3);
    trig_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    edges(3);
    rst_n = 1'b1;
    edges(1);
    outs("R1 idle after reset", 2'b11);
    edges(40);
    outs("R1 ticks ignored while idle", 2'b11);

    // R4 internal timebase shape, P=6
    period_i = 16'd6;
    trig_pulse();
    outs("R2 trigger clears chain", 2'b00);
    chk("R4 tb low after restart", {1'b0, tb_o}, 2'b00);
    edges(2); chk("R4 tb low at cnt2", {1'b0, tb_o}, 2'b00);
    edges(1); chk("R4 tb high at half", {1'b0, tb_o}, 2'b01);
    edges(2); outs("R4 no tick before P", exp_outs(0));
    edges(1); outs("R4 first tick at P", exp_outs(1));
    chk("R4 tb low after fall", {1'b0, tb_o}, 2'b00);

    // R4 period below 2 acts as 2
    period_i = 16'd0;
    trig_pulse();
    edges(2); outs("R4 min period tick1", exp_outs(1));
    edges(2); outs("R4 min period tick2", exp_outs(2));

    // R3/R6 random free-running
    for (int it = 0; it < 10; it++) begin
      int p = 2 + int'($urandom % 7);
      int n = 1 + int'($urandom % 300);
      period_i = 16'(p);
      astable_i = 1'b1;
      trig_pulse();
      edges(n * p - 1);
      outs("R3 count before tick", exp_outs(n - 1));
      edges(1);
      outs("R3 count after tick", exp_outs(n));
    end

    // R6 directed square wave
    period_i = 16'd2;
    trig_pulse();
    edges(255); outs("R6 low half end", exp_outs(127));
    edges(1);   outs("R6 rises at 128", exp_outs(128));
    edges(256); outs("R6 falls at 256", exp_outs(256));

    // R2 retrigger mid-run (n=130 so div256 high)
    edges(260); outs("R2 running before retrigger", exp_outs(130));
    trig_pulse();
    outs("R2 retrigger clears chain", 2'b00);

    // R7 reset request with trigger low
    edges(10);
    clr_i = 1'b1;
    edges(3);
    outs("R7 reset to idle", 2'b11);
    clr_i = 1'b0;
    edges(50);
    outs("R7 stays idle", 2'b11);

    // R8 trigger held high overrides reset request
    trig_i = 1'b1;
    edges(3);
    clr_i = 1'b1;
    edges(10);
    outs("R8 clr ignored while trig high", exp_outs(5));
    clr_i = 1'b0;
    trig_i = 1'b0;
    edges(4);

    // R5 one-shot pulse, P=3
    astable_i = 1'b0;
    period_i = 16'd3;
    trig_pulse();
    edges(128 * 3 - 1); outs("R5 low through tick127", exp_outs(127));
    edges(1);           outs("R5 high at tick128", exp_outs(128));
    edges(1);           outs("R5 idle after pulse", 2'b11);
    edges(30);          outs("R5 remains idle", 2'b11);

    // R8 one-shot self-reset blocked while trigger held
    period_i = 16'd2;
    trig_i = 1'b1;
    edges(3);
    edges(128 * 2 + 4); outs("R8 self-reset ignored", exp_outs(130));
    trig_i = 1'b0;
    edges(3);           outs("R8 idle once trig drops", 2'b11);

    // R9 external timebase
    astable_i = 1'b1;
    tb_ext_sel_i = 1'b1;
    tb_ext_i = 1'b1;
    edges(4);
    trig_pulse();
    outs("R9 start", 2'b00);
    for (int k = 1; k <= 6; k++) begin
      tb_ext_i = 1'b0;
      edges(2);
      chk("R9 tb_o follows ext", {1'b0, tb_o}, 2'b00);
      outs("R9 no count before latency", exp_outs(k - 1));
      edges(1);
      outs("R9 counted fall", exp_outs(k));
      tb_ext_i = 1'b1;
      edges(3 + int'($urandom % 4));
      outs("R9 rising not counted", exp_outs(k));
    end
    tb_ext_sel_i = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule